// File: doc/BRIEF.md
# Board Control Register File

This block is a small memory-mapped peripheral for board housekeeping, attached to a plain 32-bit register bus (address, write enable, write data, read enable, read data). It keeps an eight-segment LED bar value, an eight-character ASCII display buffer, a break/reset byte and a general-purpose output byte. It also drives a bit-banged two-wire serial port and reads that port's data line back from an attached memory device. All of this state appears on plain output pins, so a board-level wrapper can drive lamps, a character display and the serial pins.

The display buffer takes two kinds of write. A whole-word write turns a 32-bit value into eight uppercase hexadecimal characters. A single-character write stores one byte at one buffer position. A write of one specific value to the soft-reset register raises a one-cycle reset request. Reads return their data one cycle after the read enable is sampled. Only the low 20 address bits are decoded, so the register window repeats every megabyte.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset the LED value is 0x00, the break byte is 0x0A, the general output is 0x00, the serial output-enable is 0, the serial output is 0x3 (clock and data both high), select is 1, the soft-reset request and the serial strobe are low, and all eight display characters are ASCII space (0x20).
- R2: Writes to 0x408 (LED), 0x508 (break) and 0xA00 (general output) store only the low 8 data bits, and each register reads back zero-extended.
- R3: Only address bits 19:0 are decoded. Offsets 0x200 and 0x210 read zero, and writes to them have no effect. Any offset without a register reads zero and changes no output when written.
- R4: Offset 0x208 reads 0x12 while the big-endian strap input is 1 and 0x10 while it is 0.
- R5: A write to 0x410 replaces all eight display characters with the uppercase hex digits of the data. The most significant nibble goes to character 0 and the least significant to character 7. Digits 0-9 map to 0x30-0x39 and A-F to 0x41-0x46. Character i appears on disp_chars_o bits [8i+7:8i].
- R6: A write to offset 0x418 + 8*i (i = 0..7) stores data bits 7:0 in character i and leaves the other seven characters unchanged.
- R7: A write of exactly 0x00000042 to offset 0x500 raises soft_rst_req_o for exactly the one cycle after the write edge. Any other value at 0x500, or 0x42 written at any other offset, raises nothing.
- R8: A write to 0xB10 stores data bits 1:0, with bit 1 driving i2c_scl_o and bit 0 driving i2c_sda_o. On the same edge it raises i2c_wr_stb_o for one cycle. The register reads back at 0xB10.
- R9: Offset 0xB00 reads 0x2 with bit 0 replaced by the live slave_sda_i level.
- R10: Offset 0xB08 stores data bits 1:0 as the output-enable, and 0xB18 stores data bit 0 as select. Both read back. Offset 0xA08 returns the serial output register while select is 1 and zero while it is 0.
- R11: bus_rdata takes the addressed value on the clock edge where bus_rd is sampled high, and holds it on every edge where bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address; bits 19:0 decoded |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| strap_big_endian | input | 1 | Byte-order strap reported in the status register |
| slave_sda_i | input | 1 | Data line level returned by the serial memory |
| led_o | output | 8 | LED bar value |
| brk_o | output | 8 | Break/reset byte |
| gpo_o | output | 8 | General-purpose output byte |
| disp_chars_o | output | 64 | Display buffer, character i at bits [8i+7:8i] |
| i2c_scl_o | output | 1 | Serial clock level |
| i2c_sda_o | output | 1 | Serial data level |
| i2c_oe_o | output | 2 | Serial output-enable bits |
| i2c_sel_o | output | 1 | Serial select bit |
| i2c_wr_stb_o | output | 1 | One-cycle strobe after each serial output write |
| soft_rst_req_o | output | 1 | One-cycle soft-reset request |

## Verification
The bench checks the hex conversion with a word that mixes decimal and letter nibbles. A design with reversed nibble order or a lowercase or off-by-seven letter offset gives a wrong character string. It writes the first and last display character separately, which catches an index off by one stride or a write that spills into a neighbouring character. The soft-reset register gets a near-miss value, and the magic value is also written to an unmapped offset. A design that decodes only part of the value or the address would pulse in those cases. The bench also reads through an aliased upper address, toggles select and the slave data line, and lets read data sit idle. A mirror that ignores select, a design that decodes too many address bits, or read data that follows the bus without a read would each show a wrong value.

// File: rtl/bctl_pkg.sv
package bctl_pkg;
  localparam int OFF_W = 20;

  localparam logic [OFF_W-1:0] OFF_SWITCH  = 20'h00200;
  localparam logic [OFF_W-1:0] OFF_STATUS  = 20'h00208;
  localparam logic [OFF_W-1:0] OFF_JUMPER  = 20'h00210;
  localparam logic [OFF_W-1:0] OFF_LED     = 20'h00408;
  localparam logic [OFF_W-1:0] OFF_HEXWORD = 20'h00410;
  localparam logic [OFF_W-1:0] OFF_CHAR0   = 20'h00418;
  localparam logic [OFF_W-1:0] OFF_SOFTRST = 20'h00500;
  localparam logic [OFF_W-1:0] OFF_BRK     = 20'h00508;
  localparam logic [OFF_W-1:0] OFF_GPO     = 20'h00a00;
  localparam logic [OFF_W-1:0] OFF_MIRROR  = 20'h00a08;
  localparam logic [OFF_W-1:0] OFF_I2C_IN  = 20'h00b00;
  localparam logic [OFF_W-1:0] OFF_I2C_OE  = 20'h00b08;
  localparam logic [OFF_W-1:0] OFF_I2C_OUT = 20'h00b10;
  localparam logic [OFF_W-1:0] OFF_I2C_SEL = 20'h00b18;

  localparam logic [31:0] SOFTRST_KEY   = 32'h0000_0042;
  localparam logic [7:0]  STATUS_LE     = 8'h10;
  localparam logic [7:0]  STATUS_BE     = 8'h12;
  localparam logic [7:0]  ASCII_SPACE   = 8'h20;
  localparam logic [7:0]  BRK_RESET     = 8'h0a;
  localparam logic [1:0]  I2C_IN_STORED = 2'b10;

  function automatic logic [7:0] nibble_to_ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h37 + {4'h0, n};
  endfunction
endpackage

// File: rtl/bctl_display.sv
module bctl_display #(
  parameter int NCHAR = 8,
  localparam int IDX_W = (NCHAR > 1) ? $clog2(NCHAR) : 1,
  localparam int BUF_W = NCHAR * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_we,
  input  logic             char_we,
  input  logic [IDX_W-1:0] char_idx,
  input  logic [31:0]      wdata,
  output logic [BUF_W-1:0] chars
);
  import bctl_pkg::*;

  logic [BUF_W-1:0] chars_d;

  for (genvar i = 0; i < NCHAR; i++) begin : g_char
    always_comb begin
      chars_d[8*i +: 8] = chars[8*i +: 8];
      if (word_we)
        chars_d[8*i +: 8] = nibble_to_ascii(wdata[4*(NCHAR-1-i) +: 4]);
      else if (char_we && (char_idx == IDX_W'(i)))
        chars_d[8*i +: 8] = wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chars <= {NCHAR{ASCII_SPACE}};
    else if (word_we || char_we) chars <= chars_d;
  end

  assert_disp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(word_we || char_we) |-> $stable(chars));
endmodule

// File: rtl/bctl_i2c_port.sv
module bctl_i2c_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oe_we,
  input  logic       out_we,
  input  logic       sel_we,
  input  logic [1:0] wbits,
  output logic [1:0] oe_q,
  output logic [1:0] out_q,
  output logic       sel_q,
  output logic       stb_q
);
  logic [1:0] oe_d, out_d;
  logic       sel_d;

  always_comb begin
    oe_d  = oe_we  ? wbits    : oe_q;
    out_d = out_we ? wbits    : out_q;
    sel_d = sel_we ? wbits[0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 2'b00;
      out_q <= 2'b11;
      sel_q <= 1'b1;
      stb_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      out_q <= out_d;
      sel_q <= sel_d;
      stb_q <= out_we;
    end
  end

  assert_stb_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (out_q == $past(wbits)));
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs #(
  parameter int NCHAR = 8,
  localparam int IDX_W = (NCHAR > 1) ? $clog2(NCHAR) : 1,
  localparam int BUF_W = NCHAR * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_rd,
  output logic [31:0]      bus_rdata,
  input  logic             strap_big_endian,
  input  logic             slave_sda_i,
  output logic [7:0]       led_o,
  output logic [7:0]       brk_o,
  output logic [7:0]       gpo_o,
  output logic [BUF_W-1:0] disp_chars_o,
  output logic             i2c_scl_o,
  output logic             i2c_sda_o,
  output logic [1:0]       i2c_oe_o,
  output logic             i2c_sel_o,
  output logic             i2c_wr_stb_o,
  output logic             soft_rst_req_o
);
  import bctl_pkg::*;

  localparam logic [OFF_W-1:0] CHAR_LAST = OFF_CHAR0 + OFF_W'(8 * (NCHAR - 1));

  logic [OFF_W-1:0] off, off_rel;
  logic             unused_addr_hi;
  assign off            = bus_addr[OFF_W-1:0];
  assign unused_addr_hi = ^bus_addr[31:OFF_W];
  assign off_rel        = off - OFF_CHAR0;

  logic led_we, brk_we, gpo_we, word_we, char_we, soft_hit;
  always_comb begin
    led_we   = bus_wr && (off == OFF_LED);
    brk_we   = bus_wr && (off == OFF_BRK);
    gpo_we   = bus_wr && (off == OFF_GPO);
    word_we  = bus_wr && (off == OFF_HEXWORD);
    char_we  = bus_wr && (off >= OFF_CHAR0) && (off <= CHAR_LAST) && (off[2:0] == 3'b000);
    soft_hit = bus_wr && (off == OFF_SOFTRST) && (bus_wdata == SOFTRST_KEY);
  end

  logic [7:0]  led_d, brk_d, gpo_d;
  logic [31:0] rdata_d, rd_mux;
  logic [1:0]  i2c_out;

  always_comb begin
    led_d = led_we ? bus_wdata[7:0] : led_o;
    brk_d = brk_we ? bus_wdata[7:0] : brk_o;
    gpo_d = gpo_we ? bus_wdata[7:0] : gpo_o;
  end

  always_comb begin
    rd_mux = 32'h0;
    case (off)
      OFF_STATUS:  rd_mux = {24'h0, strap_big_endian ? STATUS_BE : STATUS_LE};
      OFF_LED:     rd_mux = {24'h0, led_o};
      OFF_BRK:     rd_mux = {24'h0, brk_o};
      OFF_GPO:     rd_mux = {24'h0, gpo_o};
      OFF_MIRROR:  rd_mux = i2c_sel_o ? {30'h0, i2c_out} : 32'h0;
      OFF_I2C_IN:  rd_mux = {30'h0, I2C_IN_STORED[1], slave_sda_i};
      OFF_I2C_OE:  rd_mux = {30'h0, i2c_oe_o};
      OFF_I2C_OUT: rd_mux = {30'h0, i2c_out};
      OFF_I2C_SEL: rd_mux = {31'h0, i2c_sel_o};
      default:     rd_mux = 32'h0;
    endcase
    rdata_d = bus_rd ? rd_mux : bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_o          <= 8'h00;
      brk_o          <= BRK_RESET;
      gpo_o          <= 8'h00;
      bus_rdata      <= 32'h0;
      soft_rst_req_o <= 1'b0;
    end else begin
      led_o          <= led_d;
      brk_o          <= brk_d;
      gpo_o          <= gpo_d;
      bus_rdata      <= rdata_d;
      soft_rst_req_o <= soft_hit;
    end
  end

  bctl_display #(.NCHAR(NCHAR)) u_display (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_we  (word_we),
    .char_we  (char_we),
    .char_idx (off_rel[3 +: IDX_W]),
    .wdata    (bus_wdata),
    .chars    (disp_chars_o)
  );

  bctl_i2c_port u_i2c (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe_we  (bus_wr && (off == OFF_I2C_OE)),
    .out_we (bus_wr && (off == OFF_I2C_OUT)),
    .sel_we (bus_wr && (off == OFF_I2C_SEL)),
    .wbits  (bus_wdata[1:0]),
    .oe_q   (i2c_oe_o),
    .out_q  (i2c_out),
    .sel_q  (i2c_sel_o),
    .stb_q  (i2c_wr_stb_o)
  );

  assign i2c_scl_o = i2c_out[1];
  assign i2c_sda_o = i2c_out[0];

  assert_softrst_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req_o |-> ($past(bus_wdata) == SOFTRST_KEY && $past(bus_wr)));
  assert_led_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> $stable(led_o));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));
  assert_no_write_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> !soft_rst_req_o && !i2c_wr_stb_o);
endmodule

// File: tb/test_board_ctl_regs.sv
module test_board_ctl_regs;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        strap_big_endian = 1'b0;
  logic        slave_sda_i = 1'b1;
  logic [7:0]  led_o, brk_o, gpo_o;
  logic [63:0] disp_chars_o;
  logic        i2c_scl_o, i2c_sda_o, i2c_sel_o, i2c_wr_stb_o, soft_rst_req_o;
  logic [1:0]  i2c_oe_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  board_ctl_regs i_board_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .strap_big_endian(strap_big_endian), .slave_sda_i(slave_sda_i),
    .led_o(led_o), .brk_o(brk_o), .gpo_o(gpo_o), .disp_chars_o(disp_chars_o),
    .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o), .i2c_oe_o(i2c_oe_o),
    .i2c_sel_o(i2c_sel_o), .i2c_wr_stb_o(i2c_wr_stb_o),
    .soft_rst_req_o(soft_rst_req_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard one cycle after each sampled read
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R11 unexpected read data", 64'(bus_rdata), 64'hdead);
      else check(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
    end
  end

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [63:0] pack_chars(input string s);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = s[i];
    return v;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 led", 64'(led_o), 64'h00);
    check("R1 brk", 64'(brk_o), 64'h0a);
    check("R1 gpo", 64'(gpo_o), 64'h00);
    check("R1 disp", disp_chars_o, pack_chars("        "));
    check("R1 i2c pins", 64'({i2c_oe_o, i2c_scl_o, i2c_sda_o, i2c_sel_o}), 64'b00111);
    check("R1 pulses", 64'({soft_rst_req_o, i2c_wr_stb_o}), 64'b00);
    bus_read(32'h0000_0b10, 32'h3, "R1 i2c out read");
    bus_read(32'h0000_0508, 32'h0a, "R1 brk read");
    bus_read(32'h0000_0a08, 32'h3, "R10 mirror sel=1");

    // R4 status strap
    strap_big_endian = 1'b0;
    bus_read(32'h0000_0208, 32'h10, "R4 status le");
    strap_big_endian = 1'b1;
    bus_read(32'h0000_0208, 32'h12, "R4 status be");

    // R2 byte registers
    bus_write(32'h0000_0408, 32'hffff_ffa5);
    check("R2 led", 64'(led_o), 64'ha5);
    bus_read(32'h0000_0408, 32'ha5, "R2 led read");
    bus_write(32'h0000_0508, 32'h1234_5677);
    bus_write(32'h0000_0a00, 32'h0000_01c3);
    check("R2 brk", 64'(brk_o), 64'h77);
    check("R2 gpo", 64'(gpo_o), 64'hc3);
    bus_read(32'h0000_0a00, 32'hc3, "R2 gpo read");

    // R3 decode
    bus_write(32'h0000_0200, 32'hffff_ffff);
    bus_read(32'h0000_0200, 32'h0, "R3 switch");
    bus_read(32'h0000_0210, 32'h0, "R3 jumper");
    bus_read(32'h0001_2344, 32'h0, "R3 unknown read");
    bus_write(32'h0000_0300, 32'hffff_ffff);
    check("R3 unknown write led", 64'(led_o), 64'ha5);
    check("R3 unknown write disp", disp_chars_o, pack_chars("        "));
    bus_write(32'hfff0_0408, 32'h0000_003c);
    check("R3 alias write", 64'(led_o), 64'h3c);
    bus_read(32'h5550_0408, 32'h3c, "R3 alias read");

    // R5 hex word
    bus_write(32'h0000_0410, 32'h1234_abcf);
    check("R5 hex word", disp_chars_o, pack_chars("1234ABCF"));
    bus_read(32'h0000_0410, 32'h0, "R3 display reads zero");

    // R6 per character
    bus_write(32'h0000_0418, 32'hffff_ff7a);
    check("R6 char0", disp_chars_o, pack_chars("z234ABCF"));
    bus_write(32'h0000_0450, 32'h0000_0021);
    check("R6 char7", disp_chars_o, pack_chars("z234ABC!"));
    bus_write(32'h0000_041c, 32'h0000_0040);
    check("R6 misaligned ignored", disp_chars_o, pack_chars("z234ABC!"));

    // R7 soft reset
    bus_write(32'h0000_0500, 32'h0000_0041);
    check("R7 near miss", 64'(soft_rst_req_o), 64'h0);
    bus_write(32'h0000_0504, 32'h0000_0042);
    check("R7 wrong offset", 64'(soft_rst_req_o), 64'h0);
    bus_write(32'h0000_0500, 32'h0000_0042);
    check("R7 pulse", 64'(soft_rst_req_o), 64'h1);
    @(negedge clk);
    check("R7 pulse width", 64'(soft_rst_req_o), 64'h0);

    // R8 serial output
    bus_write(32'h0000_0b10, 32'hffff_fff2);
    check("R8 pins", 64'({i2c_scl_o, i2c_sda_o}), 64'b10);
    check("R8 strobe", 64'(i2c_wr_stb_o), 64'h1);
    @(negedge clk);
    check("R8 strobe width", 64'(i2c_wr_stb_o), 64'h0);
    bus_read(32'h0000_0b10, 32'h2, "R8 readback");

    // R9 serial input
    slave_sda_i = 1'b0;
    bus_read(32'h0000_0b00, 32'h2, "R9 sda low");
    slave_sda_i = 1'b1;
    bus_read(32'h0000_0b00, 32'h3, "R9 sda high");

    // R10 oe, select, mirror
    bus_write(32'h0000_0b08, 32'hffff_ffff);
    check("R10 oe", 64'(i2c_oe_o), 64'h3);
    bus_read(32'h0000_0b08, 32'h3, "R10 oe read");
    bus_read(32'h0000_0a08, 32'h2, "R10 mirror value");
    bus_write(32'h0000_0b18, 32'hffff_fffe);
    check("R10 sel", 64'(i2c_sel_o), 64'h0);
    bus_read(32'h0000_0a08, 32'h0, "R10 mirror sel=0");
    bus_read(32'h0000_0b18, 32'h0, "R10 sel read");

    // R11 hold without read
    bus_read(32'h0000_0408, 32'h3c, "R11 read");
    bus_addr = 32'h0000_0208;
    repeat (3) @(negedge clk);
    check("R11 hold", 64'(bus_rdata), 64'h3c);

    repeat (2) @(negedge clk);
    check("R11 scoreboard drained", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    finish_run();
  end
endmodule